// File: doc/BRIEF.md
# Bus I/O address trap detector

This block watches a parallel system bus and reports when an I/O cycle touches one of several programmable address windows. Each window holds a 16-bit trap address and an 8-bit mask. The mask can exclude any of the low eight address bits from the comparison. Two windows serve serial ports, and each of them drives its own event line. Four more windows make up a single audio trap, and its event line fires when any one of those four matches.

The block only listens to the bus and never claims a cycle. A trap fires whether the cycle is meant for this device or for some other target. The block samples the address in the cycle in which the bus cycle-start strobe is first seen high. The matching event lines then pulse for exactly one clock in the next cycle, so power-management logic downstream can count or react to them.

Software programs the windows through a small indexed register port. Field index `2*k` holds the address of window k and index `2*k+1` holds its mask. The windows are numbered serial A = 0, serial B = 1, and audio 1 to 4 = 2 to 5.

Top module: `io_addr_trap`

## Requirements
- R1: After reset the read port returns these addresses: serial A 0x03F8, serial B 0x02F8, audio windows 1..4 0x0220, 0x0330, 0x0530 and 0x0388. It returns mask 0x000F for both serial windows and mask 0x0000 for all four audio windows. All event outputs are low.
- R2: A window matches when (bus address OR mask) equals (trap address OR mask), where the 8-bit mask is zero-extended to 16 bits.
- R3: Only address bits [7:0] can be masked, so bits [15:8] are always compared exactly. A mask write stores write-data bits [7:0], and the mask reads back zero-extended.
- R4: A match counts only when `bus_io` is high in the strobe cycle. Memory and configuration cycles (`bus_io` low) never produce an event.
- R5: When `bus_start` is first seen high, each event line for a matching window is high for exactly one clock in the next cycle. Holding `bus_start` high for more cycles produces no further pulse.
- R6: `ev_ser_a` and `ev_ser_b` follow windows 0 and 1 independently, and both can pulse in the same cycle as `ev_audio`.
- R7: `ev_audio` pulses when any of windows 2..5 matches.
- R8: A write with `cfg_we` high updates the field selected by `cfg_idx` on the next clock, and `cfg_rdata` shows the selected field. Indices 12..15 ignore writes and read as 0.
- R9: A register write made in the same cycle as a strobe does not affect that bus cycle. It applies from the next bus cycle on.
- R10: Synchronous active-high `rst` restores every field to its default and removes an event pulse that would otherwise follow a strobe in the reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Bus cycle-start strobe |
| bus_io | input | 1 | High when the current cycle is an I/O-space access |
| bus_addr | input | 16 | Bus address during the address phase |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 4 | Field index (2k = address, 2k+1 = mask of window k) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Contents of the field selected by cfg_idx |
| ev_ser_a | output | 1 | Serial A trap pulse |
| ev_ser_b | output | 1 | Serial B trap pulse |
| ev_audio | output | 1 | Audio trap pulse (OR of four windows) |

## Verification
The hardest case to reach from the ports is a register write and a bus strobe landing in the same clock. The design must then compare against the old trap address, so the new value must not leak into the cycle in progress. The stimulus writes a serial address equal to the address of the very strobe it issues in that cycle, expects no pulse, and then repeats the bus cycle to expect one. A second awkward case is a strobe that coincides with reset, or a strobe held high over several clocks. The bench drives both, and its scoreboard compares every clock's outputs, so a stray second pulse cannot go unseen.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int ADDR_W = 16;
    localparam int MASK_W = 8;
    localparam int N_WIN  = 6;
    localparam int IDX_W  = 4;
    localparam int N_FLD  = 2 * N_WIN;

    localparam int WIN_SER_A = 0;
    localparam int WIN_SER_B = 1;
    localparam int WIN_AUD_LO = 2;

    function automatic logic [ADDR_W-1:0] dflt_addr(input int k);
        case (k)
            0: dflt_addr = 16'h03F8;
            1: dflt_addr = 16'h02F8;
            2: dflt_addr = 16'h0220;
            3: dflt_addr = 16'h0330;
            4: dflt_addr = 16'h0530;
            default: dflt_addr = 16'h0388;
        endcase
    endfunction

    function automatic logic [MASK_W-1:0] dflt_mask(input int k);
        dflt_mask = (k < WIN_AUD_LO) ? 8'h0F : 8'h00;
    endfunction
endpackage

// File: rtl/trap_window.sv
module trap_window #(
    parameter int ADDR_W = 16,
    parameter int MASK_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] trap_addr,
    input  logic [MASK_W-1:0] trap_mask,
    output logic              hit
);
    localparam int PAD_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] wide_mask;

    always_comb begin
        wide_mask = {{PAD_W{1'b0}}, trap_mask};
        hit = ((addr | wide_mask) == (trap_addr | wide_mask));
    end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output logic [ADDR_W-1:0]             cfg_rdata,
    output logic [N_WIN-1:0][ADDR_W-1:0]  win_addr,
    output logic [N_WIN-1:0][MASK_W-1:0]  win_mask
);
    typedef struct packed {
        logic [N_WIN-1:0][ADDR_W-1:0] addr;
        logic [N_WIN-1:0][MASK_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        cfg_rdata = '0;
        for (int k = 0; k < N_WIN; k++) begin
            if (cfg_we && int'(cfg_idx) == 2 * k)
                regs_d.addr[k] = cfg_wdata;
            if (cfg_we && int'(cfg_idx) == 2 * k + 1)
                regs_d.mask[k] = cfg_wdata[MASK_W-1:0];
            if (int'(cfg_idx) == 2 * k)
                cfg_rdata = regs_q.addr[k];
            if (int'(cfg_idx) == 2 * k + 1)
                cfg_rdata = {{(ADDR_W-MASK_W){1'b0}}, regs_q.mask[k]};
        end
        if (rst) begin
            for (int k = 0; k < N_WIN; k++) begin
                regs_d.addr[k] = dflt_addr(k);
                regs_d.mask[k] = dflt_mask(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign win_addr = regs_q.addr;
    assign win_mask = regs_q.mask;

    assert_write_addr0_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == 4'd0) |=> (win_addr[0] == $past(cfg_wdata)));

    assert_ignore_high_idx_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && int'(cfg_idx) >= N_FLD) |=> ($stable(win_addr) && $stable(win_mask)));

    assert_reset_default_R1: assert property (@(posedge clk)
        rst |=> (win_addr[0] == 16'h03F8 && win_mask[1] == 8'h0F && win_mask[2] == 8'h00));
endmodule

// File: rtl/io_addr_trap.sv
module io_addr_trap
    import trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_start,
    input  logic        bus_io,
    input  logic [15:0] bus_addr,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_idx,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    output logic        ev_ser_a,
    output logic        ev_ser_b,
    output logic        ev_audio
);
    typedef struct packed {
        logic start;
        logic ev_a;
        logic ev_b;
        logic ev_aud;
    } state_t;

    state_t st_d, st_q;

    logic [N_WIN-1:0][ADDR_W-1:0] win_addr;
    logic [N_WIN-1:0][MASK_W-1:0] win_mask;
    logic [N_WIN-1:0]             hit;
    logic                         capture;

    trap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_addr  (win_addr),
        .win_mask  (win_mask)
    );

    for (genvar k = 0; k < N_WIN; k++) begin : g_win
        trap_window #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_win (
            .addr      (bus_addr),
            .trap_addr (win_addr[k]),
            .trap_mask (win_mask[k]),
            .hit       (hit[k])
        );
    end

    always_comb begin
        st_d = st_q;
        capture = bus_start && !st_q.start && bus_io;
        st_d.start  = bus_start;
        st_d.ev_a   = capture && hit[WIN_SER_A];
        st_d.ev_b   = capture && hit[WIN_SER_B];
        st_d.ev_aud = capture && (|hit[N_WIN-1:WIN_AUD_LO]);
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ev_ser_a = st_q.ev_a;
    assign ev_ser_b = st_q.ev_b;
    assign ev_audio = st_q.ev_aud;

    assert_pulse_origin_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_ser_a || ev_ser_b || ev_audio) |-> $past(bus_start && bus_io));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_ser_a || ev_ser_b || ev_audio) |=> !(ev_ser_a || ev_ser_b || ev_audio));

    assert_io_only_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_start && !bus_io) |=> !(ev_ser_a || ev_ser_b || ev_audio));

    assert_upper_exact_R3: assert property (@(posedge clk) disable iff (rst)
        ev_ser_a |-> ($past(bus_addr[15:8]) == $past(win_addr[WIN_SER_A][15:8])));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> !(ev_ser_a || ev_ser_b || ev_audio));
endmodule

// File: tb/io_addr_trap_tb.sv
module io_addr_trap_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, bus_start, bus_io, cfg_we;
    logic [15:0] bus_addr, cfg_wdata, cfg_rdata;
    logic [3:0]  cfg_idx;
    logic        ev_ser_a, ev_ser_b, ev_audio;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [2:0] ev;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_addr [6];
    logic [7:0]  m_mask [6];
    logic        m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_addr_trap u_dut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_io(bus_io),
        .bus_addr(bus_addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_ser_a(ev_ser_a), .ev_ser_b(ev_ser_b), .ev_audio(ev_audio)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_addr = '{16'h03F8, 16'h02F8, 16'h0220, 16'h0330, 16'h0530, 16'h0388};
        m_mask = '{8'h0F, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00};
        m_prev = 1'b0;
    endtask

    function automatic logic m_hit(input int k, input logic [15:0] a);
        return ((a | {8'h00, m_mask[k]}) == (m_addr[k] | {8'h00, m_mask[k]}));
    endfunction

    // Driver: called just after a rising edge; applies inputs for one clock
    // and pushes the outputs expected after the next rising edge.
    task automatic step(input logic r, input logic s, input logic io, input logic [15:0] a,
                        input logic we, input logic [3:0] idx, input logic [15:0] wd,
                        input string tag);
        exp_t e;
        rst = r; bus_start = s; bus_io = io; bus_addr = a;
        cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
        e.tag = tag;
        e.ev = 3'b000;
        if (r) begin
            model_reset();
        end else begin
            if (s && !m_prev && io) begin
                e.ev[2] = m_hit(0, a);
                e.ev[1] = m_hit(1, a);
                e.ev[0] = m_hit(2, a) || m_hit(3, a) || m_hit(4, a) || m_hit(5, a);
            end
            m_prev = s;
            if (we && int'(idx) < 12) begin
                if (idx[0]) m_mask[int'(idx) / 2] = wd[7:0];
                else        m_addr[int'(idx) / 2] = wd;
            end
        end
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, tag);
    endtask

    task automatic bus(input logic [15:0] a, input logic io, input string tag);
        step(1'b0, 1'b1, io, a, 1'b0, 4'd0, 16'h0000, tag);
        idle(tag);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] wd, input string tag);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, idx, wd, tag);
    endtask

    task automatic rd(input logic [3:0] idx, input logic [15:0] exp, input string tag);
        cfg_we = 1'b0; cfg_idx = idx;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Monitor: compares every clock's event outputs with the scoreboard.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " events"}, {13'd0, ev_ser_a, ev_ser_b, ev_audio}, {13'd0, e.ev});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_start = 1'b0; bus_io = 1'b0; bus_addr = '0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        model_reset();
        @(posedge clk); #1;
        step(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 4'd0, 16'h0, "R10 reset");
        step(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 4'd0, 16'h0, "R1 reset");
        idle("R1 idle");

        // R1 default values through the read port
        rd(4'd0, 16'h03F8, "R1 serA addr");
        rd(4'd1, 16'h000F, "R1 serA mask");
        rd(4'd2, 16'h02F8, "R1 serB addr");
        rd(4'd3, 16'h000F, "R1 serB mask");
        rd(4'd4, 16'h0220, "R1 aud1 addr");
        rd(4'd6, 16'h0330, "R1 aud2 addr");
        rd(4'd8, 16'h0530, "R1 aud3 addr");
        rd(4'd10, 16'h0388, "R1 aud4 addr");
        rd(4'd5, 16'h0000, "R1 aud1 mask");
        rd(4'd11, 16'h0000, "R1 aud4 mask");
        rd(4'd13, 16'h0000, "R8 unused idx");

        // R2/R6 serial matches, masked low bits
        bus(16'h03F8, 1'b1, "R6 serA exact");
        bus(16'h03FF, 1'b1, "R2 serA masked");
        bus(16'h02F3, 1'b1, "R6 serB masked");
        bus(16'h13F8, 1'b1, "R3 upper byte exact");
        bus(16'h03E8, 1'b1, "R2 unmasked bit4");
        // R7 audio windows
        bus(16'h0220, 1'b1, "R7 aud1");
        bus(16'h0221, 1'b1, "R7 aud1 no mask");
        bus(16'h0388, 1'b1, "R7 aud4");
        bus(16'h0530, 1'b1, "R7 aud3");
        // R4 non-I/O cycle
        bus(16'h03F8, 1'b0, "R4 memory cycle");
        // R5 held strobe gives one pulse
        step(1'b0, 1'b1, 1'b1, 16'h02F8, 1'b0, 4'd0, 16'h0, "R5 held 1");
        step(1'b0, 1'b1, 1'b1, 16'h02F8, 1'b0, 4'd0, 16'h0, "R5 held 2");
        step(1'b0, 1'b1, 1'b1, 16'h02F8, 1'b0, 4'd0, 16'h0, "R5 held 3");
        idle("R5 release");
        // R3 mask write keeps low byte only
        wr(4'd9, 16'hABF0, "R3 mask write");
        rd(4'd9, 16'h00F0, "R3 mask readback");
        bus(16'h05A0, 1'b1, "R7 aud3 masked");
        // R9 write during strobe applies to the next bus cycle only
        step(1'b0, 1'b1, 1'b1, 16'h1234, 1'b1, 4'd0, 16'h1234, "R9 write with strobe");
        idle("R9 gap");
        bus(16'h1234, 1'b1, "R9 next cycle");
        // R8 ignored index
        wr(4'd14, 16'hFFFF, "R8 ignored write");
        rd(4'd14, 16'h0000, "R8 ignored readback");
        rd(4'd0, 16'h1234, "R8 field kept");
        // R6 serial B and audio in the same cycle
        wr(4'd2, 16'h0220, "R8 serB addr write");
        wr(4'd3, 16'h0000, "R8 serB mask write");
        rd(4'd2, 16'h0220, "R8 serB readback");
        bus(16'h0220, 1'b1, "R6 serB with audio");
        // R10 reset during strobe
        step(1'b1, 1'b1, 1'b1, 16'h0220, 1'b0, 4'd0, 16'h0, "R10 reset with strobe");
        idle("R10 after reset");
        rd(4'd0, 16'h03F8, "R10 serA default");
        rd(4'd2, 16'h02F8, "R10 serB default");
        rd(4'd9, 16'h0000, "R10 aud3 mask default");
        bus(16'h03F1, 1'b1, "R2 after reset");
        idle("drain");
        @(negedge clk); #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule